// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Guard and Address Marking

This block is the sending half of a serial port. A character is written into a one-entry holding register. It moves into a shift stage as soon as that stage has no bits left to start. From there it is sent on a single line, least significant bit first: a low start bit, then five to eight data bits, an optional parity bit, and one or two high stop bits. The line idles high. The same framing serves both clocked and unclocked links. The bit timing comes from an external single-cycle strobe, and the line moves only on cycles where that strobe is asserted.

A programmable guard count appends that many high bit periods after every character, which spaces the characters out for slow receivers. A multidrop parity setting replaces the parity bit with an address marker. A one-shot send-address command makes the next accepted character go out with the marker set. All later characters go out with it cleared. Two status outputs tell the writer when the holding register can take a new character and when nothing at all is left to send.

Top module: `ser_char_tx`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `txd` is 1, `txRdy` is 1 and `txEmpty` is 1, and any pending send-address request is dropped.
- R2: A frame is a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then the stop bits (1). `txd` changes only on an edge where `bitTick` is 1, and holds each bit for one strobe period.
- R3: `cfgLen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. `cfgTwoStop` = 0 selects one stop bit and 1 selects two.
- R4: `cfgPar` selects the parity bit: 000 gives even parity over the sent data bits, 001 gives odd parity, 010 gives a constant 0, 011 gives a constant 1, and 100 or 101 give no parity bit.
- R5: A write (`holdWr`) is accepted only when `txRdy` is 1. After an accepted write `txRdy` is 0 from the next edge on. A write while `txRdy` is 0 is ignored: it produces no frame and does not change the character already held.
- R6: The held character moves to the shift stage one cycle after the last bit of the previous frame (guard bits included) has started, and `txRdy` returns to 1 at that edge. If `bitTick` is low in that cycle, consecutive frames follow with no idle bit between them.
- R7: `txEmpty` is 1 exactly when the holding register is empty and every bit of the current frame, guard bits included, has started.
- R8: With `cfgGuard` = N, the line stays high for N extra bit periods after the last stop bit before any next start bit. N = 0 adds none.
- R9: With `cfgPar` = 110 or 111, the parity position carries 1 for the first character accepted at or after a `sendAddrCmd` pulse (a pulse in the same cycle as the accepted write counts), and 0 for every other character.
- R10: A `sendAddrCmd` pulse that arrives together with an ignored write stays pending and marks the next accepted character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitTick | input | 1 | One-cycle bit-period strobe |
| cfgLen | input | 2 | Data bit count select (5 + value) |
| cfgPar | input | 3 | Parity / multidrop mode |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| cfgGuard | input | GUARD_W | Idle bit periods after each frame |
| holdWr | input | 1 | Write strobe for the holding register |
| holdData | input | DATA_W | Character to send |
| sendAddrCmd | input | 1 | Mark the next accepted character as an address |
| txd | output | 1 | Serial line, idles high |
| txRdy | output | 1 | Holding register can take a character |
| txEmpty | output | 1 | Holding register empty and no frame bits left to start |

## Verification
Two functions can fall in the same cycle. In the first, a send-address command arrives with a write. The bench pulses the command together with an accepted write, and also together with a write refused because the holding register is full. It then checks that the address marker lands on the character the bench model predicts. In the second, a character is refilled while the previous frame is still on the line. A second character is written during the first frame, and a third write is attempted while the holding register is still full. The bench then judges the frame-by-frame line pattern, the number of idle periods between frames, and the count of frames that actually appear.

// File: rtl/ser_char_tx_pkg.sv
package ser_char_tx_pkg;

  // control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic holdLoad;   // accept the incoming character
    logic markAddr;   // accepted character carries the address marker
    logic shiftLoad;  // move held character into the shift stage
    logic shiftStep;  // put the next frame bit on the line
  } txStrobe_t;

  // parity modes 10x carry no parity bit
  function automatic logic hasParity(input logic [2:0] par);
    return par[2:1] != 2'b10;
  endfunction

  // parity modes 11x mark address characters
  function automatic logic isMultidrop(input logic [2:0] par);
    return par[2:1] == 2'b11;
  endfunction

endpackage

// File: rtl/ser_char_tx_ctrl.sv
module ser_char_tx_ctrl
  import ser_char_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bitTick,
  input  logic [1:0]         cfgLen,
  input  logic [2:0]         cfgPar,
  input  logic               cfgTwoStop,
  input  logic [GUARD_W-1:0] cfgGuard,
  input  logic               holdWr,
  input  logic               sendAddrCmd,
  output txStrobe_t          strobe,
  output logic               txRdy,
  output logic               txEmpty
);

  localparam int MIN_BITS = DATA_W - 3;
  localparam int FRAME_W  = DATA_W + 4;
  localparam int CNT_W    = $clog2(FRAME_W + (1 << GUARD_W));

  logic             holdFull;
  logic             addrPending;
  logic [CNT_W-1:0] bitsLeft;
  logic [CNT_W-1:0] loadCount;
  logic             shiftIdle;

  // bits to start for one frame: start + data + parity + stop(s) + guard
  always_comb begin
    loadCount = CNT_W'(2 + MIN_BITS)
              + CNT_W'(cfgLen)
              + CNT_W'(hasParity(cfgPar))
              + CNT_W'(cfgTwoStop)
              + CNT_W'(cfgGuard);
  end

  assign shiftIdle = (bitsLeft == '0);

  always_comb begin
    strobe.holdLoad  = holdWr && !holdFull;
    strobe.markAddr  = addrPending || sendAddrCmd;
    strobe.shiftLoad = shiftIdle && holdFull;
    strobe.shiftStep = bitTick && !shiftIdle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdFull    <= 1'b0;
      addrPending <= 1'b0;
      bitsLeft    <= '0;
    end else begin
      if (strobe.holdLoad)       holdFull <= 1'b1;
      else if (strobe.shiftLoad) holdFull <= 1'b0;

      if (strobe.holdLoad)  addrPending <= 1'b0;
      else if (sendAddrCmd) addrPending <= 1'b1;

      if (strobe.shiftLoad)      bitsLeft <= loadCount;
      else if (strobe.shiftStep) bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign txRdy   = !holdFull;
  assign txEmpty = !holdFull && shiftIdle;

  // R5
  rdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (txRdy && holdWr) |=> !txRdy);

  // R7
  empty_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    txEmpty |-> txRdy);

  // R10
  addr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sendAddrCmd && !txRdy) |=> addrPending);

  // R6
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (holdFull && bitsLeft == '0) |=> (txRdy && bitsLeft != '0));

endmodule

// File: rtl/ser_char_tx_dpath.sv
module ser_char_tx_dpath
  import ser_char_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobe_t         strobe,
  input  logic [1:0]        cfgLen,
  input  logic [2:0]        cfgPar,
  input  logic [DATA_W-1:0] holdData,
  output logic              txd
);

  localparam int MIN_BITS = DATA_W - 3;
  localparam int FRAME_W  = DATA_W + 4;
  localparam int BODY_W   = FRAME_W - 1;

  logic [DATA_W-1:0]  holdByte;
  logic               holdAddr;
  logic [FRAME_W-1:0] frameReg;
  logic [FRAME_W-1:0] frameNext;
  logic [DATA_W-1:0]  sentData;
  logic [BODY_W-1:0]  body;
  logic               parBit;
  logic               parOn;
  int                 nBits;

  always_comb begin
    nBits    = MIN_BITS + int'(cfgLen);
    sentData = holdByte & ~({DATA_W{1'b1}} << nBits);
    parOn    = hasParity(cfgPar);
    if (isMultidrop(cfgPar)) parBit = holdAddr;
    else begin
      case (cfgPar[1:0])
        2'b00:   parBit = ^sentData;
        2'b01:   parBit = ~^sentData;
        2'b10:   parBit = 1'b0;
        default: parBit = 1'b1;
      endcase
    end
    // data, then parity, then ones for stop bits and beyond
    body = BODY_W'(sentData)
         | (BODY_W'(parBit && parOn) << nBits)
         | ({BODY_W{1'b1}} << (nBits + int'(parOn)));
    frameNext = {body, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdByte <= '0;
      holdAddr <= 1'b0;
      frameReg <= '1;
      txd      <= 1'b1;
    end else begin
      if (strobe.holdLoad) begin
        holdByte <= holdData;
        holdAddr <= strobe.markAddr;
      end
      if (strobe.shiftLoad) frameReg <= frameNext;
      else if (strobe.shiftStep) begin
        txd      <= frameReg[0];
        frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
      end
    end
  end

  // R2
  txd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftStep |=> $stable(txd));

  // R2
  start_head_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.shiftLoad |=> !frameReg[0]);

endmodule

// File: rtl/ser_char_tx.sv
module ser_char_tx
  import ser_char_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bitTick,
  input  logic [1:0]         cfgLen,
  input  logic [2:0]         cfgPar,
  input  logic               cfgTwoStop,
  input  logic [GUARD_W-1:0] cfgGuard,
  input  logic               holdWr,
  input  logic [DATA_W-1:0]  holdData,
  input  logic               sendAddrCmd,
  output logic               txd,
  output logic               txRdy,
  output logic               txEmpty
);

  txStrobe_t strobe;

  ser_char_tx_ctrl #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bitTick     (bitTick),
    .cfgLen      (cfgLen),
    .cfgPar      (cfgPar),
    .cfgTwoStop  (cfgTwoStop),
    .cfgGuard    (cfgGuard),
    .holdWr      (holdWr),
    .sendAddrCmd (sendAddrCmd),
    .strobe      (strobe),
    .txRdy       (txRdy),
    .txEmpty     (txEmpty)
  );

  ser_char_tx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .cfgLen   (cfgLen),
    .cfgPar   (cfgPar),
    .holdData (holdData),
    .txd      (txd)
  );

  // R2
  line_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !bitTick |=> $stable(txd));

endmodule

// File: tb/ser_char_tx_tb.sv
`timescale 1ns/1ps
module ser_char_tx_tb;

  localparam int DATA_W  = 8;
  localparam int GUARD_W = 8;
  localparam int TICK_P  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitTick = 1'b0;
  logic [1:0] cfgLen = 2'd3;
  logic [2:0] cfgPar = 3'b100;
  logic cfgTwoStop = 1'b0;
  logic [GUARD_W-1:0] cfgGuard = '0;
  logic holdWr = 1'b0;
  logic [DATA_W-1:0] holdData = '0;
  logic sendAddrCmd = 1'b0;
  logic txd, txRdy, txEmpty;

  ser_char_tx #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_dut (
    .clk(clk), .rst(rst), .bitTick(bitTick), .cfgLen(cfgLen), .cfgPar(cfgPar),
    .cfgTwoStop(cfgTwoStop), .cfgGuard(cfgGuard), .holdWr(holdWr),
    .holdData(holdData), .sendAddrCmd(sendAddrCmd), .txd(txd),
    .txRdy(txRdy), .txEmpty(txEmpty)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit pend = 0;
  bit bitQ[$];
  int lenQ[$];
  int remaining = 0;
  int gapCnt = 0;
  int lastGap = -1;
  int framesSeen = 0;
  int framesSent = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected frame from the requirements (R2 R3 R4 R8 R9)
  task automatic pushFrame(input logic [7:0] d, input bit addr);
    int nb = 5 + int'(cfgLen);
    int n = 0;
    bit p = 0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    bitQ.push_back(1'b0); n++;
    for (int i = 0; i < nb; i++) begin bitQ.push_back(d[i]); n++; end
    if (cfgPar[2:1] != 2'b10) begin
      case (cfgPar)
        3'b000: bitQ.push_back(p);
        3'b001: bitQ.push_back(~p);
        3'b010: bitQ.push_back(1'b0);
        3'b011: bitQ.push_back(1'b1);
        default: bitQ.push_back(addr);
      endcase
      n++;
    end
    for (int i = 0; i < 1 + int'(cfgTwoStop) + int'(cfgGuard); i++) begin
      bitQ.push_back(1'b1); n++;
    end
    lenQ.push_back(n);
    framesSent++;
  endtask

  task automatic sampleLine();
    bit e;
    if (remaining > 0) begin
      e = bitQ.pop_front();
      chk(txd == e, "R2 R3 R4 R8 R9", "frame bit", int'(txd), int'(e));
      remaining--;
      if (remaining == 0) gapCnt = 0;
    end else if (txd == 1'b0) begin
      if (lenQ.size() == 0) begin
        chk(1'b0, "R5", "unexpected frame start", 0, 1);
      end else begin
        remaining = lenQ.pop_front() - 1;
        e = bitQ.pop_front();
        lastGap = gapCnt;
        framesSeen++;
        chk(e == 1'b0, "R2", "start bit", int'(txd), int'(e));
      end
    end else gapCnt++;
  endtask

  // bit strobe generator and line monitor in one process
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (bitTick && !rst) sampleLine();
      cnt = (cnt + 1) % TICK_P;
      bitTick = (cnt == TICK_P - 1);
    end
  end

  task automatic writeChar(input logic [7:0] d, input bit withCmd);
    @(negedge clk);
    while (!txRdy) @(negedge clk);
    holdWr = 1'b1; holdData = d; sendAddrCmd = withCmd;
    pushFrame(d, pend | withCmd);
    pend = 0;
    @(negedge clk);
    holdWr = 1'b0; sendAddrCmd = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (lenQ.size() != 0 || remaining != 0 || !txEmpty) @(negedge clk);
    repeat (2 * TICK_P) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    sendAddrCmd = 1'b1;            // pending request must be dropped by reset
    @(negedge clk);
    sendAddrCmd = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(txRdy == 1'b1, "R1", "txRdy after reset", int'(txRdy), 1);
    chk(txEmpty == 1'b1, "R1", "txEmpty after reset", int'(txEmpty), 1);

    // R1: no address marker survives reset (multidrop, plain write)
    cfgPar = 3'b110; cfgLen = 2'd3; cfgTwoStop = 1'b0; cfgGuard = '0;
    writeChar(8'h3c, 1'b0);
    waitIdle();

    // R5 R6 R7 flag timing on a write into an idle block
    cfgPar = 3'b000;
    @(negedge clk);
    holdWr = 1'b1; holdData = 8'ha5;
    pushFrame(8'ha5, 1'b0);
    @(negedge clk);
    holdWr = 1'b0;
    chk(txRdy == 1'b0, "R5", "txRdy after accepted write", int'(txRdy), 0);
    chk(txEmpty == 1'b0, "R7", "txEmpty with held char", int'(txEmpty), 0);
    @(negedge clk);
    chk(txRdy == 1'b1, "R6", "txRdy after transfer", int'(txRdy), 1);
    chk(txEmpty == 1'b0, "R7", "txEmpty while shifting", int'(txEmpty), 0);

    // R5 R6: refill while busy, then an ignored write
    writeChar(8'h5a, 1'b0);
    chk(txRdy == 1'b0, "R5", "txRdy with full hold", int'(txRdy), 0);
    holdWr = 1'b1; holdData = 8'hff;   // ignored: hold register full
    @(negedge clk);
    holdWr = 1'b0;
    chk(txRdy == 1'b0, "R5", "txRdy after ignored write", int'(txRdy), 0);
    while (framesSeen < framesSent) @(negedge clk);
    chk(lastGap == 0, "R6", "idle periods between frames", lastGap, 0);
    waitIdle();
    chk(framesSeen == framesSent, "R5", "frames on line", framesSeen, framesSent);
    chk(txEmpty == 1'b1, "R7", "txEmpty when done", int'(txEmpty), 1);

    // R8 guard gap of 5 periods between back-to-back frames
    cfgGuard = 8'd5; cfgPar = 3'b011; cfgTwoStop = 1'b1;
    writeChar(8'h81, 1'b0);
    writeChar(8'h7e, 1'b0);
    waitIdle();
    chk(lastGap == 0, "R8", "start right after guard", lastGap, 0);

    // R9 R10 multidrop marker placement
    cfgGuard = '0; cfgPar = 3'b111; cfgTwoStop = 1'b0; cfgLen = 2'd2;
    @(negedge clk); sendAddrCmd = 1'b1; pend = 1;
    @(negedge clk); sendAddrCmd = 1'b0;
    writeChar(8'h11, 1'b0);           // R9 marked
    writeChar(8'h22, 1'b0);           // R9 unmarked
    writeChar(8'h33, 1'b1);           // R9 same-cycle command
    @(negedge clk);
    while (txRdy) @(negedge clk);
    holdWr = 1'b1; holdData = 8'h99; sendAddrCmd = 1'b1; pend = 1;  // R10
    @(negedge clk);
    holdWr = 1'b0; sendAddrCmd = 1'b0;
    writeChar(8'h44, 1'b0);           // R10 marked by pending command
    writeChar(8'h55, 1'b0);
    waitIdle();
    chk(framesSeen == framesSent, "R10", "frames on line", framesSeen, framesSent);

    // random configurations and characters
    for (int c = 0; c < 40; c++) begin
      cfgLen = 2'($urandom_range(0, 3));
      cfgPar = 3'($urandom_range(0, 7));
      cfgTwoStop = 1'($urandom_range(0, 1));
      cfgGuard = GUARD_W'($urandom_range(0, 3));
      for (int k = 0; k < 5; k++) begin
        bit cmd = ($urandom_range(0, 3) == 0);
        if (cmd && $urandom_range(0, 1) == 1) begin
          @(negedge clk); sendAddrCmd = 1'b1; pend = 1;
          @(negedge clk); sendAddrCmd = 1'b0;
          cmd = 0;
        end
        writeChar(8'($urandom_range(0, 255)), cmd);
      end
      waitIdle();
      chk(txEmpty == 1'b1, "R7", "txEmpty after batch", int'(txEmpty), 1);
    end
    chk(framesSeen == framesSent, "R3", "total frames", framesSeen, framesSent);
    chk(bitQ.size() == 0, "R2", "leftover expected bits", bitQ.size(), 0);
    finishRun();
  end

endmodule